// File: doc/BRIEF.md
# Raster Timing Generator with Jumping Counters

This block produces the line and frame timing for a tile-based video display processor. A horizontal position counter and a vertical line counter both run through non-contiguous sequences. Inside each sequence they skip from one value to a much higher value. The block derives the horizontal and vertical blanking status from exact counter values. It raises a one-cycle line interrupt request and a held frame interrupt request. It also keeps a frame-interrupt pending flag, which an acknowledge strobe clears.

The counters advance only on clock cycles where the pixel-rate enable is high. A column-mode input picks between a narrow line, 32 tile columns, and a wide line, 40 tile columns. The frame is the 313-line, 224-visible-line format of 50 Hz systems. A change of column mode is taken up only at the start of the next line. This means a line already in progress always finishes with the jump that belongs to its own mode.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first enabled cycle, `hcount` holds the post-jump value of the selected mode (0xE9 when `wide_mode`=0, 0xE4 when `wide_mode`=1) and `vcount` holds 0x00. `hblank`, `vblank`, `hint`, `vint` and `vint_pending` are all 0.
- R2: With `wide_mode`=0 (32 columns), each enabled cycle moves `hcount` as follows. It counts 0x00 up to 0x93, then jumps to 0xE9, counts up to 0xFF, then wraps to 0x00. A line is 171 enabled cycles.
- R3: With `wide_mode`=1 (40 columns), `hcount` counts 0x00 up to 0xB6, then jumps to 0xE4, counts up to 0xFF, then wraps to 0x00. A line is 211 enabled cycles.
- R4: `hblank` becomes 1 in the same cycle that `hcount` takes its post-jump value. It becomes 0 in the cycle that `hcount` becomes 0x06.
- R5: `hint` is high for exactly one clock cycle. That cycle is the one in which `hcount` first shows the post-jump value. `hint` is low at all other times.
- R6: `vcount` changes only in the cycle in which `hcount` becomes 0x85.
- R7: Over one frame, `vcount` steps through three runs: 0x00 to 0xFF, then 0x00 to 0x02, then 0xCA to 0xFF. It then returns to 0x00 for the next frame, for 313 lines in all.
- R8: `vblank` becomes 1 when `vcount` steps to 0xE0 in the first 0x00 to 0xFF run. It stays 1 until `vcount` steps to 0xFF in the 0xCA to 0xFF run, where it becomes 0.
- R9: `vint` and `vint_pending` rise together in the cycle where `hcount` wraps from 0xFF to 0x00 while `vcount` is 0xE0 in the first run. This does not happen in the 0xCA to 0xFF run. Both then stay 1 until an `irq_ack` cycle, after which both read 0.
- R10: A change of `wide_mode` in the middle of a line does not alter the jump of that line. The new mode governs `hcount` from the next wrap to 0x00 onward.
- R11: In a cycle with `pix_ce` low, `hcount`, `vcount`, `hblank` and `vblank` keep their values, and `hint` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pix_ce | input | 1 | Pixel-rate clock enable; counters advance only when high |
| wide_mode | input | 1 | Column mode: 0 = 32 columns, 1 = 40 columns |
| irq_ack | input | 1 | Frame interrupt acknowledge strobe |
| hcount | output | 8 | Horizontal counter value |
| vcount | output | 8 | Vertical counter value |
| hblank | output | 1 | Horizontal blanking status |
| vblank | output | 1 | Vertical blanking status |
| vint_pending | output | 1 | Frame interrupt pending flag |
| hint | output | 1 | Line interrupt request, one-cycle pulse |
| vint | output | 1 | Frame interrupt request, held until acknowledged |

## Verification
The counter sequences are tested with a table of cycle offsets from reset, in both column modes. The table samples the cycles just before and just after each jump, wrap, 0x06 blank clear and 0x85 line step, which separates an off-by-one in any one of these thresholds. A full narrow frame is run to find the vertical events: the 0xE0 blank start, the interrupt at the wrap on that line, the second 0x00 run, the 0xCA resume and the 0xFF blank end. The 0xE0 line of the late run is used to tell a phase-aware interrupt from one that decodes the line value alone. Separate directed runs cover the following: a stalled enable held across a jump, a mid-line mode change, and holding the interrupt across several cycles before the acknowledge.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int unsigned CW = 8;
  typedef logic [CW-1:0] cnt_t;

  typedef enum logic [1:0] {
    VPH_MAIN = 2'd0,
    VPH_TAIL = 2'd1,
    VPH_LATE = 2'd2
  } vphase_t;

  localparam cnt_t H32_LAST     = 8'h93;
  localparam cnt_t H32_RESUME   = 8'hE9;
  localparam cnt_t H40_LAST     = 8'hB6;
  localparam cnt_t H40_RESUME   = 8'hE4;
  localparam cnt_t HB_CLEAR_AT  = 8'h06;
  localparam cnt_t V_STEP_AT    = 8'h85;
  localparam cnt_t V_TAIL_LAST  = 8'h02;
  localparam cnt_t V_LATE_FIRST = 8'hCA;
  localparam cnt_t VB_SET_AT    = 8'hE0;
  localparam cnt_t VB_CLEAR_AT  = 8'hFF;
  localparam cnt_t VINT_LINE    = 8'hE0;

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount
  import raster_pkg::*;
#(
  parameter cnt_t NARROW_LAST   = H32_LAST,
  parameter cnt_t NARROW_RESUME = H32_RESUME,
  parameter cnt_t WIDE_LAST     = H40_LAST,
  parameter cnt_t WIDE_RESUME   = H40_RESUME,
  parameter cnt_t BLANK_END     = HB_CLEAR_AT,
  parameter cnt_t LINE_STEP     = V_STEP_AT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic wide_req,
  output cnt_t h_o,
  output logic hblank_o,
  output logic jump_evt_o,
  output logic wrap_evt_o,
  output logic vstep_o
);

  localparam cnt_t TOP_VAL = '1;

  logic mode_q, mode_d;
  cnt_t h_q, h_d;
  logic hb_q, hb_d;
  cnt_t last_val, resume_val;
  logic at_last, at_top;

  // jump points of the mode latched for the current line
  always_comb begin
    last_val   = mode_q ? WIDE_LAST   : NARROW_LAST;
    resume_val = mode_q ? WIDE_RESUME : NARROW_RESUME;
    at_last    = (h_q == last_val);
    at_top     = (h_q == TOP_VAL);
  end

  always_comb begin
    h_d    = h_q;
    mode_d = mode_q;
    hb_d   = hb_q;
    if (ce) begin
      if (at_last) begin
        h_d  = resume_val;
        hb_d = 1'b1;
      end else if (at_top) begin
        h_d    = '0;
        mode_d = wide_req;
      end else begin
        h_d = cnt_t'(h_q + 1'b1);
      end
      if (!at_last && (h_d == BLANK_END)) begin
        hb_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= wide_req;
      h_q    <= wide_req ? WIDE_RESUME : NARROW_RESUME;
      hb_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      h_q    <= h_d;
      hb_q   <= hb_d;
    end
  end

  assign h_o        = h_q;
  assign hblank_o   = hb_q;
  assign jump_evt_o = ce && at_last;
  assign wrap_evt_o = ce && at_top;
  assign vstep_o    = ce && (h_d == LINE_STEP);

  // R11: a disabled cycle leaves the counter and blank flag untouched
  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(h_q) && $stable(hb_q)));

  // R4: blank rises only on the cycle after a jump was taken
  a_r4_blank_rise_on_jump: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_q) |-> (h_q == $past(resume_val)));

  // R4: blank falls only where the counter shows the clear value
  a_r4_blank_fall_at_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hb_q) |-> (h_q == BLANK_END));

  // R10: the latched mode only moves on a line start
  a_r10_mode_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> (h_q == '0));

endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
  import raster_pkg::*;
#(
  parameter cnt_t TAIL_LAST  = V_TAIL_LAST,
  parameter cnt_t LATE_FIRST = V_LATE_FIRST,
  parameter cnt_t BLANK_ON   = VB_SET_AT,
  parameter cnt_t BLANK_OFF  = VB_CLEAR_AT,
  parameter cnt_t IRQ_LINE   = VINT_LINE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output cnt_t v_o,
  output logic vblank_o,
  output logic irq_line_o
);

  localparam cnt_t TOP_VAL = '1;

  cnt_t    v_q, v_d;
  vphase_t ph_q, ph_d;
  logic    vb_q, vb_d;

  always_comb begin
    v_d  = v_q;
    ph_d = ph_q;
    vb_d = vb_q;
    if (step) begin
      unique case (ph_q)
        VPH_MAIN: begin
          if (v_q == TOP_VAL) begin
            v_d  = '0;
            ph_d = VPH_TAIL;
          end else begin
            v_d = cnt_t'(v_q + 1'b1);
          end
        end
        VPH_TAIL: begin
          if (v_q == TAIL_LAST) begin
            v_d  = LATE_FIRST;
            ph_d = VPH_LATE;
          end else begin
            v_d = cnt_t'(v_q + 1'b1);
          end
        end
        VPH_LATE: begin
          if (v_q == TOP_VAL) begin
            v_d  = '0;
            ph_d = VPH_MAIN;
          end else begin
            v_d = cnt_t'(v_q + 1'b1);
          end
        end
        default: begin
          v_d  = '0;
          ph_d = VPH_MAIN;
        end
      endcase
      if ((ph_d == VPH_MAIN) && (v_d == BLANK_ON)) begin
        vb_d = 1'b1;
      end else if ((ph_d == VPH_LATE) && (v_d == BLANK_OFF)) begin
        vb_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      ph_q <= VPH_MAIN;
      vb_q <= 1'b0;
    end else begin
      v_q  <= v_d;
      ph_q <= ph_d;
      vb_q <= vb_d;
    end
  end

  assign v_o        = v_q;
  assign vblank_o   = vb_q;
  assign irq_line_o = (ph_q == VPH_MAIN) && (v_q == IRQ_LINE);

  // R7: the short run never goes past its last value
  a_r7_tail_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == VPH_TAIL) |-> (v_q <= TAIL_LAST));

  // R7: the late run starts no lower than its resume value
  a_r7_late_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == VPH_LATE) |-> (v_q >= LATE_FIRST));

  // R8: during the first run, blanking means the blank start was reached
  a_r8_blank_in_main: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_q && (ph_q == VPH_MAIN)) |-> (v_q >= BLANK_ON));

  // R8: the short run always lies inside blanking
  a_r8_blank_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == VPH_TAIL) |-> vb_q);

endmodule

// File: rtl/raster_irq.sv
module raster_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic hjump,
  input  logic vfire,
  input  logic ack,
  output logic hint_o,
  output logic vint_o
);

  logic hint_q, hint_d;
  logic vint_q, vint_d;

  always_comb begin
    hint_d = hjump;
    vint_d = vint_q;
    if (vfire) begin
      vint_d = 1'b1;
    end else if (ack) begin
      vint_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hint_q <= 1'b0;
      vint_q <= 1'b0;
    end else begin
      hint_q <= hint_d;
      vint_q <= vint_d;
    end
  end

  assign hint_o = hint_q;
  assign vint_o = vint_q;

  // R5: the line request never lasts beyond one cycle
  a_r5_hint_single: assert property (@(posedge clk) disable iff (!rst_n)
    hint_q |=> !hint_q);

  // R9: a raised frame request survives until acknowledged
  a_r9_vint_held: assert property (@(posedge clk) disable iff (!rst_n)
    (vint_q && !ack) |=> vint_q);

  // R9: the frame request rises only from a fire event
  a_r9_vint_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vint_q) |-> $past(vfire));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_ce,
  input  logic       wide_mode,
  input  logic       irq_ack,
  output logic [7:0] hcount,
  output logic [7:0] vcount,
  output logic       hblank,
  output logic       vblank,
  output logic       vint_pending,
  output logic       hint,
  output logic       vint
);

  cnt_t h_val, v_val;
  logic jump_evt, wrap_evt, vstep, irq_line, vfire;

  raster_hcount u_hcount (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (pix_ce),
    .wide_req   (wide_mode),
    .h_o        (h_val),
    .hblank_o   (hblank),
    .jump_evt_o (jump_evt),
    .wrap_evt_o (wrap_evt),
    .vstep_o    (vstep)
  );

  raster_vcount u_vcount (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (vstep),
    .v_o        (v_val),
    .vblank_o   (vblank),
    .irq_line_o (irq_line)
  );

  assign vfire = wrap_evt && irq_line;

  raster_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .hjump  (jump_evt),
    .vfire  (vfire),
    .ack    (irq_ack),
    .hint_o (hint),
    .vint_o (vint)
  );

  assign hcount       = h_val;
  assign vcount       = v_val;
  assign vint_pending = vint;

  // R6: the line counter moves only where the position shows the step value
  a_r6_vstep_position: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(v_val) |-> (h_val == V_STEP_AT));

  // R5: a line request always coincides with horizontal blanking
  a_r5_hint_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    hint |-> hblank);

  // R9: a fresh frame request lands on the first position of a line
  a_r9_vint_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vint) |-> (h_val == '0));

endmodule

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;

  logic       clk;
  logic       rst_n;
  logic       pix_ce;
  logic       wide_mode;
  logic       irq_ack;
  logic [7:0] hcount, vcount;
  logic       hblank, vblank, vint_pending, hint, vint;

  int total;
  int bad;
  int cur_n;

  raster_timing_gen dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_ce       (pix_ce),
    .wide_mode    (wide_mode),
    .irq_ack      (irq_ack),
    .hcount       (hcount),
    .vcount       (vcount),
    .hblank       (hblank),
    .vblank       (vblank),
    .vint_pending (vint_pending),
    .hint         (hint),
    .vint         (vint)
  );

  initial clk = 1'b0;
  always #2.5ns clk = ~clk;

  typedef struct packed {
    logic        wide;
    logic [15:0] n;
    logic [7:0]  h;
    logic [7:0]  v;
    logic        hb;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'd0,   8'hE9, 8'h00, 1'b0},
    '{1'b0, 16'd22,  8'hFF, 8'h00, 1'b0},
    '{1'b0, 16'd23,  8'h00, 8'h00, 1'b0},
    '{1'b0, 16'd29,  8'h06, 8'h00, 1'b0},
    '{1'b0, 16'd155, 8'h84, 8'h00, 1'b0},
    '{1'b0, 16'd156, 8'h85, 8'h01, 1'b0},
    '{1'b0, 16'd170, 8'h93, 8'h01, 1'b0},
    '{1'b0, 16'd171, 8'hE9, 8'h01, 1'b1},
    '{1'b0, 16'd193, 8'hFF, 8'h01, 1'b1},
    '{1'b0, 16'd194, 8'h00, 8'h01, 1'b1},
    '{1'b0, 16'd199, 8'h05, 8'h01, 1'b1},
    '{1'b0, 16'd200, 8'h06, 8'h01, 1'b0},
    '{1'b1, 16'd0,   8'hE4, 8'h00, 1'b0},
    '{1'b1, 16'd27,  8'hFF, 8'h00, 1'b0},
    '{1'b1, 16'd28,  8'h00, 8'h00, 1'b0},
    '{1'b1, 16'd160, 8'h84, 8'h00, 1'b0},
    '{1'b1, 16'd161, 8'h85, 8'h01, 1'b0},
    '{1'b1, 16'd210, 8'hB6, 8'h01, 1'b0},
    '{1'b1, 16'd211, 8'hE4, 8'h01, 1'b1},
    '{1'b1, 16'd239, 8'h00, 8'h01, 1'b1},
    '{1'b1, 16'd244, 8'h05, 8'h01, 1'b1},
    '{1'b1, 16'd245, 8'h06, 8'h01, 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (pix_ce) cur_n++;
  endtask

  task automatic do_reset(input logic wide);
    @(negedge clk);
    rst_n     = 1'b0;
    wide_mode = wide;
    pix_ce    = 1'b1;
    irq_ack   = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_n = 0;
  endtask

  task automatic run_to(input int n);
    while (cur_n < n) tick();
  endtask

  initial begin
    #(5ns * 150000);
    total++;
    bad++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    cur_n = 0;
    rst_n = 1'b0;
    pix_ce = 1'b1;
    wide_mode = 1'b0;
    irq_ack = 1'b0;

    // R1: values held during reset
    @(negedge clk);
    @(negedge clk);
    chk("R1", "h in reset", hcount, 8'hE9);
    chk("R1", "v in reset", vcount, 8'h00);
    chk("R1", "flags in reset", {hblank, vblank, hint, vint, vint_pending}, 0);

    // R2 R3 R4 R6: vector table walk
    for (int i = 0; i < NV; i++) begin
      if (i == 0 || VECS[i].wide != VECS[i-1].wide) do_reset(VECS[i].wide);
      run_to(int'(VECS[i].n));
      chk(VECS[i].wide ? "R3" : "R2", $sformatf("h at n=%0d", VECS[i].n), hcount, VECS[i].h);
      chk("R6", $sformatf("v at n=%0d", VECS[i].n), vcount, VECS[i].v);
      chk("R4", $sformatf("hblank at n=%0d", VECS[i].n), hblank, VECS[i].hb);
      if (VECS[i].n == 0) chk("R1", "flags after release", {hblank, vblank, hint, vint}, 0);
    end

    // R5: single-cycle line request at the jump
    do_reset(1'b0);
    run_to(170);
    chk("R5", "hint before jump", hint, 0);
    tick();
    chk("R5", "hint at jump", hint, 1);
    tick();
    chk("R5", "hint after jump", hint, 0);

    // R11: stalled enable across the jump point
    do_reset(1'b0);
    run_to(170);
    pix_ce = 1'b0;
    for (int k = 0; k < 5; k++) tick();
    chk("R11", "h frozen", hcount, 8'h93);
    chk("R11", "hblank frozen", hblank, 0);
    chk("R11", "hint quiet", hint, 0);
    chk("R11", "v frozen", vcount, 8'h01);
    pix_ce = 1'b1;
    tick();
    chk("R11", "h resumes with jump", hcount, 8'hE9);
    chk("R11", "hint after resume", hint, 1);

    // R10: mode change mid-line
    do_reset(1'b0);
    run_to(100);
    wide_mode = 1'b1;
    run_to(170);
    chk("R10", "old last value kept", hcount, 8'h93);
    tick();
    chk("R10", "old jump kept", hcount, 8'hE9);
    run_to(194);
    chk("R10", "wrap", hcount, 8'h00);
    run_to(376);
    chk("R10", "new last value", hcount, 8'hB6);
    tick();
    chk("R10", "new jump", hcount, 8'hE4);

    // R7 R8 R9: full narrow frame
    do_reset(1'b0);
    run_to(38288);
    chk("R8", "v before blank", vcount, 8'hDF);
    chk("R8", "vblank before", vblank, 0);
    tick();
    chk("R8", "v at blank start", vcount, 8'hE0);
    chk("R8", "vblank set", vblank, 1);
    run_to(38326);
    chk("R9", "vint before wrap", vint, 0);
    tick();
    chk("R9", "h at wrap", hcount, 8'h00);
    chk("R9", "vint at wrap", vint, 1);
    chk("R9", "pending at wrap", vint_pending, 1);
    run_to(38330);
    chk("R9", "vint held", vint, 1);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    chk("R9", "vint after ack", vint, 0);
    chk("R9", "pending after ack", vint_pending, 0);
    run_to(43761);
    chk("R7", "second run start", vcount, 8'h00);
    chk("R8", "vblank in short run", vblank, 1);
    run_to(44274);
    chk("R7", "late run resume", vcount, 8'hCA);
    run_to(48074);
    chk("R7", "late E0 line", vcount, 8'hE0);
    chk("R9", "no vint on late E0", vint, 0);
    tick();
    chk("R9", "no pending on late E0", vint_pending, 0);
    run_to(53336);
    chk("R7", "v before end", vcount, 8'hFE);
    chk("R8", "vblank before end", vblank, 1);
    tick();
    chk("R7", "v at end", vcount, 8'hFF);
    chk("R8", "vblank cleared", vblank, 0);
    run_to(53508);
    chk("R7", "next frame", vcount, 8'h00);
    chk("R8", "vblank in new frame", vblank, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule